// File: doc/BRIEF.md
# Programmable Sync Character Hunt Receiver

This block is the front end of a synchronous serial receiver. It takes one serial bit on each clock cycle in which the bit enable is high. While it is in hunt, it compares the most recent bits against a programmable sync pattern. The pattern can be 6, 8, 12 or 16 bits long. It is loaded from two 8-bit pattern inputs, and how its bits are packed into those inputs depends on the selected length.

When the pattern matches, the block leaves hunt and pulses a sync-detected output for one cycle. It then assembles characters of 5 to 8 bits and presents each finished character with a one-cycle valid strobe. In the external-sync mode the comparator is not used: an outside circuit ends the hunt by pulling an active-low sync input low. A synchronous enter-hunt command returns the block to hunt at any time.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, hunting is 1 and sync_det, char_valid and char_data are all 0.
- R2: When mode_sel is not 2'b11, mode_sel[0] and len_x select the pattern length: mode_sel[0]=0 with len_x=1 gives 6 bits; mode_sel[0]=0 with len_x=0 gives 8 bits; mode_sel[0]=1 with len_x=1 gives 12 bits; mode_sel[0]=1 with len_x=0 gives 16 bits.
- R3: The pattern is taken from the two pattern inputs as follows:
  - 8 bits: pat_hi[7:0].
  - 16 bits: {pat_hi, pat_lo}.
  - 12 bits: {pat_hi, pat_lo[7:4]}. pat_lo[3:0] is unused.
  - 6 bits: pat_hi[7:2]. pat_hi[1:0] is unused.
- R4: The earliest received bit of the N-bit window is compared against pattern bit 0. The window includes the bit sampled in the current enabled cycle. Only bits received since the last reset or enter_hunt count toward a match.
- R5: A match is found on a clock edge that samples a bit with rx_en high. In the next cycle hunting is 0 and sync_det is 1, and sync_det is 1 for that one cycle only.
- R6: Cycles with rx_en low shift in no bit and change neither the hunt state nor the character progress.
- R7: Once out of hunt, characters are 5 + char_bits bits wide. The first bit after the sync is placed in char_data[0], and char_data bits above the width read 0. char_valid is high for one cycle, in the cycle after the edge that samples the character's last bit.
- R8: char_valid is never high while hunting is 1.
- R9: With mode_sel = 2'b11 the comparator is ignored and the block stays in hunt while ext_sync_n is high. An enabled edge that samples ext_sync_n low ends the hunt and pulses sync_det. The bit sampled on that edge is not part of any character, and the next enabled bit becomes character bit 0.
- R10: sync_stat follows the ext_sync_n level when mode_sel = 2'b11. In all other modes it equals hunting.
- R11: When enter_hunt is high on an edge, the next cycle shows hunting = 1 with no sync_det and no char_valid. The partial character is discarded, and the full pattern must be received again before a match.
- R12: A window that differs from the pattern in any one bit does not end the hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Bit enable: rx_bit is sampled on this edge |
| rx_bit | input | 1 | Serial data bit |
| mode_sel | input | 2 | Length/external mode select (2'b11 = external sync) |
| len_x | input | 1 | Extra length select bit |
| pat_hi | input | 8 | Upper pattern register |
| pat_lo | input | 8 | Lower pattern register |
| char_bits | input | 2 | Character width minus 5 |
| ext_sync_n | input | 1 | Active-low external sync |
| enter_hunt | input | 1 | Synchronous command to re-enter hunt |
| hunting | output | 1 | 1 while searching for sync |
| sync_det | output | 1 | One-cycle pulse when the hunt ends |
| sync_stat | output | 1 | Sync/hunt status |
| char_data | output | 8 | Assembled character, first bit in bit 0 |
| char_valid | output | 1 | One-cycle strobe for char_data |

## Verification
The assertions check several properties on every cycle:
- sync_det is a single-cycle pulse that always coincides with leaving hunt.
- char_valid never appears during hunt and never lasts two cycles.
- External mode with ext_sync_n high always keeps the hunt.
- enter_hunt always restores hunt with the outputs quiet.

Other properties depend on particular bit streams, so only the bench scenarios can show them:
- the pattern packing for each length and the bit order of the comparison;
- the exact cycle of detection;
- character contents and widths;
- the effect of enable gaps and one-bit mismatches;
- the need to refill the window after enter_hunt.

// File: rtl/sync_hunt_pkg.sv
`timescale 1ns/1ps
package sync_hunt_pkg;

    localparam int WIN_W    = 16;
    localparam int FILL_W   = $clog2(WIN_W + 1);
    localparam int CHAR_W   = 8;
    localparam int MIN_CHAR = 5;
    localparam int CNT_W    = $clog2(CHAR_W);

    typedef enum logic [1:0] {
        LEN_6  = 2'd0,
        LEN_8  = 2'd1,
        LEN_12 = 2'd2,
        LEN_16 = 2'd3
    } sync_len_e;

    typedef struct packed {
        logic      ext;
        sync_len_e len;
    } rx_mode_t;

    typedef struct packed {
        logic [WIN_W-1:0] pat;
        logic [WIN_W-1:0] mask;
    } sync_ref_t;

    function automatic rx_mode_t decode_mode(input logic [1:0] sel, input logic xbit);
        rx_mode_t m;
        m.ext = &sel;
        if (sel[0]) m.len = xbit ? LEN_12 : LEN_16;
        else        m.len = xbit ? LEN_6  : LEN_8;
        return m;
    endfunction

    function automatic int unsigned len_bits(input sync_len_e len);
        case (len)
            LEN_6:   return 6;
            LEN_8:   return 8;
            LEN_12:  return 12;
            default: return 16;
        endcase
    endfunction

    // Pattern is placed at the top of the window: window bit WIN_W-N+i holds pattern bit i.
    function automatic sync_ref_t build_ref(input sync_len_e len,
                                            input logic [7:0] hi,
                                            input logic [7:0] lo);
        sync_ref_t r;
        logic [WIN_W-1:0] raw;
        int unsigned n;
        n = len_bits(len);
        case (len)
            LEN_6:   raw = {10'd0, hi[7:2]};
            LEN_8:   raw = {8'd0, hi};
            LEN_12:  raw = {4'd0, hi, lo[7:4]};
            default: raw = {hi, lo};
        endcase
        r.pat  = raw << (WIN_W - n);
        r.mask = {WIN_W{1'b1}} << (WIN_W - n);
        return r;
    endfunction

endpackage

// File: rtl/shr_window.sv
`timescale 1ns/1ps
module shr_window
    import sync_hunt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              clear,
    input  logic              rx_bit,
    output logic [WIN_W-1:0]  win_next,
    output logic [FILL_W-1:0] fill
);
    logic [WIN_W-1:0] sh_q;

    // Newest bit enters at the top; the oldest bit of an N-bit window sits lowest.
    assign win_next = {rx_bit, sh_q[WIN_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            fill <= '0;
        end else if (clear) begin
            fill <= '0;
        end else if (bit_en) begin
            sh_q <= win_next;
            if (fill != FILL_W'(WIN_W)) fill <= fill + 1'b1;
        end
    end
endmodule

// File: rtl/sync_cmp.sv
`timescale 1ns/1ps
module sync_cmp
    import sync_hunt_pkg::*;
(
    input  sync_len_e         len,
    input  logic [7:0]        pat_hi,
    input  logic [7:0]        pat_lo,
    input  logic [WIN_W-1:0]  win,
    input  logic [FILL_W-1:0] fill,
    output logic              hit
);
    sync_ref_t        ref_w;
    logic [WIN_W-1:0] diff;
    logic [FILL_W-1:0] need;
    logic             enough;

    always_comb begin
        ref_w  = build_ref(len, pat_hi, pat_lo);
        diff   = (win ^ ref_w.pat) & ref_w.mask;
        need   = FILL_W'(len_bits(len) - 1);
        enough = (fill >= need);
        hit    = enough && (diff == '0);
    end
endmodule

// File: rtl/char_asm.sv
`timescale 1ns/1ps
module char_asm
    import sync_hunt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic [1:0]        width_sel,
    output logic [CHAR_W-1:0] data,
    output logic              valid
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CHAR_W-1:0] acc_q;
    logic [CHAR_W-1:0] acc_next;
    logic [CNT_W-1:0]  last_idx;

    assign last_idx = CNT_W'(MIN_CHAR - 1) + CNT_W'(width_sel);

    always_comb begin
        acc_next        = acc_q;
        acc_next[cnt_q] = rx_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            acc_q <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (clear) begin
                cnt_q <= '0;
                acc_q <= '0;
            end else if (bit_en) begin
                if (cnt_q == last_idx) begin
                    data  <= acc_next;
                    valid <= 1'b1;
                    cnt_q <= '0;
                    acc_q <= '0;
                end else begin
                    acc_q <= acc_next;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sync_hunt_rx.sv
`timescale 1ns/1ps
module sync_hunt_rx
    import sync_hunt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_en,
    input  logic        rx_bit,
    input  logic [1:0]  mode_sel,
    input  logic        len_x,
    input  logic [7:0]  pat_hi,
    input  logic [7:0]  pat_lo,
    input  logic [1:0]  char_bits,
    input  logic        ext_sync_n,
    input  logic        enter_hunt,
    output logic        hunting,
    output logic        sync_det,
    output logic        sync_stat,
    output logic [7:0]  char_data,
    output logic        char_valid
);
    rx_mode_t          mode;
    logic [WIN_W-1:0]  win_next;
    logic [FILL_W-1:0] fill;
    logic              hit;
    logic              found;
    logic              asm_clear;
    logic              asm_en;

    assign mode = decode_mode(mode_sel, len_x);

    shr_window u_win (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (rx_en),
        .clear    (enter_hunt),
        .rx_bit   (rx_bit),
        .win_next (win_next),
        .fill     (fill)
    );

    sync_cmp u_cmp (
        .len    (mode.len),
        .pat_hi (pat_hi),
        .pat_lo (pat_lo),
        .win    (win_next),
        .fill   (fill),
        .hit    (hit)
    );

    assign found = mode.ext ? !ext_sync_n : hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            hunting  <= 1'b1;
            sync_det <= 1'b0;
        end else begin
            sync_det <= 1'b0;
            if (enter_hunt) begin
                hunting <= 1'b1;
            end else if (rx_en && hunting && found) begin
                hunting  <= 1'b0;
                sync_det <= 1'b1;
            end
        end
    end

    assign asm_clear = enter_hunt || hunting;
    assign asm_en    = rx_en && !hunting;

    char_asm u_asm (
        .clk       (clk),
        .rst       (rst),
        .clear     (asm_clear),
        .bit_en    (asm_en),
        .rx_bit    (rx_bit),
        .width_sel (char_bits),
        .data      (char_data),
        .valid     (char_valid)
    );

    assign sync_stat = mode.ext ? ext_sync_n : hunting;
endmodule

// File: rtl/sync_hunt_chk.sv
`timescale 1ns/1ps
module sync_hunt_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       ext_sync_n,
    input logic       enter_hunt,
    input logic       hunting,
    input logic       sync_det,
    input logic       char_valid
);
    a_r5_det_single: assert property (@(posedge clk) disable iff (rst)
        sync_det |=> !sync_det);

    a_r5_det_leaves_hunt: assert property (@(posedge clk) disable iff (rst)
        sync_det |-> !hunting);

    a_r8_no_char_in_hunt: assert property (@(posedge clk) disable iff (rst)
        hunting |-> !char_valid);

    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid);

    a_r9_ext_holds_hunt: assert property (@(posedge clk) disable iff (rst)
        (hunting && mode_sel == 2'b11 && ext_sync_n) |=> hunting);

    a_r11_enter_restores: assert property (@(posedge clk) disable iff (rst)
        enter_hunt |=> (hunting && !sync_det && !char_valid));
endmodule

bind sync_hunt_rx sync_hunt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .ext_sync_n (ext_sync_n),
    .enter_hunt (enter_hunt),
    .hunting    (hunting),
    .sync_det   (sync_det),
    .char_valid (char_valid)
);

// File: tb/tb_sync_hunt_rx.sv
`timescale 1ns/1ps
module tb_sync_hunt_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       len_x = 1'b0;
    logic [7:0] pat_hi = 8'h00;
    logic [7:0] pat_lo = 8'h00;
    logic [1:0] char_bits = 2'b11;
    logic       ext_sync_n = 1'b1;
    logic       enter_hunt = 1'b0;
    logic       hunting, sync_det, sync_stat, char_valid;
    logic [7:0] char_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    sync_hunt_rx dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit),
        .mode_sel(mode_sel), .len_x(len_x), .pat_hi(pat_hi), .pat_lo(pat_lo),
        .char_bits(char_bits), .ext_sync_n(ext_sync_n), .enter_hunt(enter_hunt),
        .hunting(hunting), .sync_det(sync_det), .sync_stat(sync_stat),
        .char_data(char_data), .char_valid(char_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each character strobe.
    always @(negedge clk) begin
        if (!rst && char_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8 unexpected char", char_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(char_data == e, "R7 char_data", char_data, e);
            end
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_en  = 1'b1;
        rx_bit = b;
        @(posedge clk);
        #1 rx_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_en  = 1'b0;
            rx_bit = i[0];
        end
    endtask

    task automatic send_word(input logic [15:0] v, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            send_bit(v[i]);
            if (gaps) idle(2);
        end
    endtask

    task automatic send_char(input logic [7:0] v, input int w);
        logic [7:0] m;
        m = v & ((8'd1 << w) - 8'd1);
        exp_q.push_back(m);
        send_word({8'd0, v}, w, 1'b0);
    endtask

    task automatic pulse_enter;
        @(negedge clk);
        enter_hunt = 1'b1;
        @(negedge clk);
        enter_hunt = 1'b0;
        check(hunting == 1'b1, "R11 hunting after enter_hunt", hunting, 1);
        check(sync_det == 1'b0, "R11 no sync_det after enter_hunt", sync_det, 0);
    endtask

    // Ones preamble, then the pattern; the last bit must produce the detection.
    task automatic sync_on(input logic [15:0] p, input int n, input string req, input bit gaps);
        send_word(16'hFFFF, n, 1'b0);
        send_word(p, n - 1, gaps);
        #1 check(hunting == 1'b1, {req, " still hunting before last bit"}, hunting, 1);
        send_bit(p[n-1]);
        @(negedge clk);
        check(hunting == 1'b0, {req, " R5 hunt cleared"}, hunting, 0);
        check(sync_det == 1'b1, {req, " R5 sync_det"}, sync_det, 1);
        @(negedge clk);
        check(sync_det == 1'b0, "R5 sync_det one cycle", sync_det, 0);
    endtask

    initial begin
        #(4 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(hunting == 1'b1, "R1 hunting", hunting, 1);
        check(sync_det == 1'b0, "R1 sync_det", sync_det, 0);
        check(char_valid == 1'b0, "R1 char_valid", char_valid, 0);
        check(char_data == 8'h00, "R1 char_data", char_data, 0);
        check(sync_stat == 1'b1, "R10 sync_stat internal", sync_stat, 1);

        // R2/R3/R4: 8-bit, pattern = pat_hi; pat_lo unused
        mode_sel = 2'b00; len_x = 1'b0; pat_hi = 8'h96; pat_lo = 8'hFF; char_bits = 2'b11;
        pulse_enter();
        sync_on(16'h0096, 8, "R2 R3 R4 8-bit", 1'b0);
        check(sync_stat == 1'b0, "R10 sync_stat follows hunting", sync_stat, 0);
        send_char(8'h5A, 8);
        send_char(8'hC3, 8);
        idle(2);

        // R12: 16-bit with one flipped bit, then the true pattern
        mode_sel = 2'b01; len_x = 1'b0; pat_hi = 8'hEB; pat_lo = 8'h3C; char_bits = 2'b00;
        pulse_enter();
        send_word(16'hFFFF, 16, 1'b0);
        send_word(16'hEB3C ^ 16'h0200, 16, 1'b0);
        @(negedge clk);
        check(hunting == 1'b1, "R12 one-bit mismatch keeps hunt", hunting, 1);
        sync_on(16'hEB3C, 16, "R2 R3 16-bit", 1'b0);
        send_char(8'h13, 5);
        send_char(8'hEE, 5);
        idle(2);

        // R6: 12-bit with enable gaps carrying garbage bits
        mode_sel = 2'b01; len_x = 1'b1; pat_hi = 8'h4D; pat_lo = 8'h6F; char_bits = 2'b01;
        pulse_enter();
        sync_on(16'h04D6, 12, "R2 R3 R6 12-bit gaps", 1'b1);
        send_char(8'h2B, 6);
        idle(3);
        send_char(8'hFF, 6);
        idle(2);

        // 6-bit: pattern = pat_hi[7:2]
        mode_sel = 2'b00; len_x = 1'b1; pat_hi = 8'hB3; pat_lo = 8'h00; char_bits = 2'b10;
        pulse_enter();
        sync_on(16'h002C, 6, "R2 R3 6-bit", 1'b0);
        send_char(8'h71, 7);
        idle(2);

        // R11: partial character discarded, window must refill
        mode_sel = 2'b00; len_x = 1'b0; pat_hi = 8'h96; char_bits = 2'b11;
        pulse_enter();
        sync_on(16'h0096, 8, "R11 first sync", 1'b0);
        send_word(16'h0007, 3, 1'b0);
        pulse_enter();
        sync_on(16'h0096, 8, "R11 resync", 1'b0);
        send_char(8'h3E, 8);
        idle(2);
        pat_hi = 8'h00;
        pulse_enter();
        send_word(16'h0000, 7, 1'b0);
        @(negedge clk);
        check(hunting == 1'b1, "R11 R4 fill needed after enter_hunt", hunting, 1);
        send_bit(1'b0);
        @(negedge clk);
        check(sync_det == 1'b1, "R11 R4 match on eighth bit", sync_det, 1);
        idle(2);

        // R9/R10: external sync
        mode_sel = 2'b11; len_x = 1'b0; pat_hi = 8'h96; ext_sync_n = 1'b1; char_bits = 2'b11;
        pulse_enter();
        check(sync_stat == 1'b1, "R10 sync_stat high level", sync_stat, 1);
        send_word(16'hFFFF, 8, 1'b0);
        send_word(16'h0096, 8, 1'b0);
        @(negedge clk);
        check(hunting == 1'b1, "R9 comparator bypassed", hunting, 1);
        ext_sync_n = 1'b0;
        #1 check(sync_stat == 1'b0, "R10 sync_stat low level", sync_stat, 0);
        send_bit(1'b1);
        @(negedge clk);
        check(hunting == 1'b0, "R9 hunt ended by ext sync", hunting, 0);
        check(sync_det == 1'b1, "R9 sync_det", sync_det, 1);
        ext_sync_n = 1'b1;
        send_char(8'hA6, 8);
        idle(3);

        check(exp_q.size() == 0, "R7 all characters delivered", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule